// File: doc/BRIEF.md
# PLL Divider Search Engine

This block picks the input (pre) divider and the feedback divider for the PLL of a serial display PHY. It is given a target lane bit rate and a reference clock frequency, both as integers in kHz. For a display link the target is normally six times the pixel clock, and the reference is normally 24000 kHz. The byte clock that follows from the result is the lane rate divided by 8.

The phase comparator must run between 5 MHz and 40 MHz, and this window sets the range of pre-divider candidates. One shared sequential divider tries them in turn, lowest first. It keeps the candidate whose feedback product leaves the smallest remainder against the reference, provided the feedback divider it implies is below the allowed maximum. When the search ends, the block reports:
- the chosen dividers and the rate they actually achieve;
- the bytes ready to write into the PHY's test-code registers;
- one of two error flags: the reference is unusable, or no candidate qualifies.

A one-cycle start pulse launches a run, and a one-cycle done pulse ends it. The results stay unchanged until the next run completes.

Top module: `pll_div_search`

## Requirements
- R1: With the reference in kHz, the pre-divider upper bound is refclk/5000 (integer division). The lower bound is refclk/40000 + 1, or 1 when that quotient is 0.
- R2: When the upper bound is below the lower bound, the run ends with err_ref_o = 1 and err_nosol_o = 0. prediv_o, fbdiv_o, rate_o and all four bytes are 0.
- R3: Candidates i run from the lower bound up to the upper bound minus one, in increasing order. A candidate becomes the choice only when (target·i) mod refclk is strictly below the best remainder so far and (target·i)/refclk < MAX_FB (512). On equal remainders the lowest i is kept.
- R4: fbdiv_o = target·prediv/refclk and rate_o = refclk·fbdiv_o/prediv_o, both by integer division.
- R5: When no candidate qualifies, including an empty candidate range, the run ends with err_nosol_o = 1 and err_ref_o = 0. All divider, rate and byte outputs are 0.
- R6: On success, the three divider bytes are:
  - in_div_byte_o = prediv−1 (low 8 bits);
  - fb_lo_byte_o = (fbdiv−1) & 0x1F;
  - fb_hi_byte_o = ((fbdiv−1) >> 5) | 0x80.
- R7: On success, vco_byte_o = 0x80 | (((target/200000) & 0xF) << 3) | 0x3. On either error it is 0.
- R8: done_o is high for exactly one cycle per run, and busy_o is high from the cycle after start is taken until done. A start pulse while busy is ignored. All results hold their values between runs.
- R9: After reset, busy_o, done_o, both error flags and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse; the targets are sampled with it |
| target_i | input | FREQ_W (24) | Target lane bit rate in kHz |
| refclk_i | input | FREQ_W (24) | Reference clock frequency in kHz |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_ref_o | output | 1 | Reference outside the usable range |
| err_nosol_o | output | 1 | No candidate qualified |
| prediv_o | output | PRE_W (12) | Chosen pre-divider |
| fbdiv_o | output | FB_W (9) | Chosen feedback divider |
| rate_o | output | FREQ_W (24) | Achieved lane rate in kHz |
| in_div_byte_o | output | 8 | Input divider register byte |
| fb_lo_byte_o | output | 8 | Low feedback divider register byte |
| fb_hi_byte_o | output | 8 | High feedback divider register byte |
| vco_byte_o | output | 8 | VCO range register byte |

## Verification
The search is run with several input pairs, and each one separates a different part of the rule:
- An exact multiple, where every candidate leaves remainder 0, shows that ties keep the lowest pre-divider.
- A typical display rate on a 24 MHz reference gives the lowest remainder at the first candidate.
- A 100 MHz reference moves the window up so that it starts at 3.
- A 30 MHz case has the smallest remainders only at feedback values of 512 and above, so they must be skipped.

Reference values of 4000 and 0 kHz exercise the bad-reference path. A 12 MHz case, whose only candidate overflows the feedback limit, exercises the no-solution path. A start pulse given mid-run, and idle cycles after a result, show that the outputs cannot be disturbed between runs.

// File: rtl/pll_srch_pkg.sv
// Package: shared state encoding for the PLL divider search engine.
// Assumes: used only by pll_div_search.
package pll_srch_pkg;

    // Sequencer states; each division step waits in its own state.
    typedef enum logic [2:0] {
        S_IDLE,
        S_MAXP,
        S_MINP,
        S_VCOR,
        S_CHK,
        S_SRCH,
        S_RATE,
        S_DONE
    } srch_state_e;

endpackage

// File: rtl/pll_seq_div.sv
// Module: pll_seq_div
// Restoring unsigned divider, one quotient bit per clock.
// Assumes: den_i is nonzero whenever start_i is pulsed; the operands are
// sampled on start_i. The result is ready NUM_W cycles later, marked by a
// one-cycle done_o, and holds until the next start.
module pll_seq_div #(
    parameter int NUM_W = 36,
    parameter int DEN_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [DEN_W-1:0] den_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [NUM_W-1:0] quo_o,
    output logic [DEN_W-1:0] rem_o
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [DEN_W-1:0] den_q;
    logic [CNT_W-1:0] cnt_q;
    logic [DEN_W:0]   trial;
    logic [DEN_W:0]   diff;
    logic             ge;

    // Partial remainder shifted left with the next dividend bit, then a trial subtraction.
    always_comb begin
        trial = {rem_o, quo_o[NUM_W-1]};
        diff  = trial - {1'b0, den_q};
        ge    = (trial >= {1'b0, den_q});
    end

    // Step sequencer: load, NUM_W shift/subtract steps, then a done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            den_q  <= '0;
            cnt_q  <= '0;
            busy_o <= 1'b0;
            done_o <= 1'b0;
            quo_o  <= '0;
            rem_o  <= '0;
        end else begin
            done_o <= 1'b0;
            if (start_i && !busy_o) begin
                den_q  <= den_i;
                quo_o  <= num_i;
                rem_o  <= '0;
                cnt_q  <= CNT_W'(NUM_W);
                busy_o <= 1'b1;
            end else if (busy_o) begin
                rem_o <= ge ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
                quo_o <= {quo_o[NUM_W-2:0], ge};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    busy_o <= 1'b0;
                    done_o <= 1'b1;
                end
            end
        end
    end

    // R4: a finished division always leaves a remainder below the divisor.
    a_r4_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (rem_o < den_q));

    // R8: completion of a division is a single-cycle event.
    a_r8_div_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

// File: rtl/pll_code_pack.sv
// Module: pll_code_pack
// Turns the chosen dividers and the VCO band index into PHY register bytes.
// Assumes: FB_W >= 5. While ok_i is low, every byte is zero.
module pll_code_pack #(
    parameter int PRE_W = 12,
    parameter int FB_W  = 9
) (
    input  logic             ok_i,
    input  logic [PRE_W-1:0] prediv_i,
    input  logic [FB_W-1:0]  fbdiv_i,
    input  logic [3:0]       vco_band_i,
    output logic [7:0]       in_div_byte_o,
    output logic [7:0]       fb_lo_byte_o,
    output logic [7:0]       fb_hi_byte_o,
    output logic [7:0]       vco_byte_o
);
    logic [FB_W-1:0] fb_m1;

    // Minus-one encodings: the feedback divider is split into a 5-bit low part
    // and a flagged high part.
    always_comb begin
        fb_m1 = fbdiv_i - FB_W'(1);
        if (ok_i) begin
            in_div_byte_o = 8'(prediv_i - PRE_W'(1));
            fb_lo_byte_o  = {3'b000, fb_m1[4:0]};
            fb_hi_byte_o  = 8'h80 | 8'(fb_m1 >> 5);
            vco_byte_o    = {1'b1, vco_band_i, 3'b011};
        end else begin
            in_div_byte_o = '0;
            fb_lo_byte_o  = '0;
            fb_hi_byte_o  = '0;
            vco_byte_o    = '0;
        end
    end

endmodule

// File: rtl/pll_div_search.sv
// Module: pll_div_search
// Sequential search for the PLL pre/feedback dividers with the smallest
// remainder. One shared divider computes the window bounds, the VCO band,
// every candidate and the achieved rate.
// Assumes: frequencies in kHz; refclk may be zero (it is reported as an error);
// the target is below 16 * VCO_STEP if the VCO band is to be meaningful.
module pll_div_search #(
    parameter int FREQ_W   = 24,
    parameter int WIN_LO   = 5000,
    parameter int WIN_HI   = 40000,
    parameter int VCO_STEP = 200000,
    parameter int MAX_FB   = 512,
    localparam int PRE_W   = $clog2((2 ** FREQ_W) / WIN_LO + 1),
    localparam int FB_W    = $clog2(MAX_FB)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [FREQ_W-1:0] target_i,
    input  logic [FREQ_W-1:0] refclk_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_ref_o,
    output logic              err_nosol_o,
    output logic [PRE_W-1:0]  prediv_o,
    output logic [FB_W-1:0]   fbdiv_o,
    output logic [FREQ_W-1:0] rate_o,
    output logic [7:0]        in_div_byte_o,
    output logic [7:0]        fb_lo_byte_o,
    output logic [7:0]        fb_hi_byte_o,
    output logic [7:0]        vco_byte_o
);
    import pll_srch_pkg::*;

    localparam int NUM_W = FREQ_W + PRE_W;

    srch_state_e       state;
    logic [FREQ_W-1:0] tgt_q, ref_q;
    logic [PRE_W-1:0]  max_pre, min_pre, cand, best_pre;
    logic [FB_W-1:0]   best_fb;
    logic [FREQ_W-1:0] best_rem, rate_w;
    logic [3:0]        band_w, band_o;
    logic              found, w_eref, w_enos, res_ok;
    logic              div_go, div_busy, div_done;
    logic [NUM_W-1:0]  div_num, div_quo;
    logic [FREQ_W-1:0] div_den, div_rem;
    logic              take;
    logic [PRE_W-1:0]  nxt_pre, sel_pre;
    logic [FB_W-1:0]   sel_fb;

    pll_seq_div #(.NUM_W(NUM_W), .DEN_W(FREQ_W)) div_u (
        .clk(clk), .rst_n(rst_n), .start_i(div_go), .num_i(div_num),
        .den_i(div_den), .busy_o(div_busy), .done_o(div_done),
        .quo_o(div_quo), .rem_o(div_rem)
    );

    // Candidate acceptance and the choice it leads to.
    always_comb begin
        take    = (div_rem < best_rem) && (div_quo < NUM_W'(MAX_FB));
        nxt_pre = cand + PRE_W'(1);
        sel_pre = take ? cand : best_pre;
        sel_fb  = take ? div_quo[FB_W-1:0] : best_fb;
    end

    // Search sequencer: bounds, VCO band, candidate sweep, rate, commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            tgt_q <= '0;  ref_q <= '0;
            max_pre <= '0; min_pre <= '0; cand <= '0;
            best_pre <= '0; best_fb <= '0; best_rem <= '1;
            rate_w <= '0; band_w <= '0; found <= 1'b0;
            w_eref <= 1'b0; w_enos <= 1'b0;
            div_go <= 1'b0; div_num <= '0; div_den <= '0;
            busy_o <= 1'b0; done_o <= 1'b0; res_ok <= 1'b0;
            err_ref_o <= 1'b0; err_nosol_o <= 1'b0;
            prediv_o <= '0; fbdiv_o <= '0; rate_o <= '0; band_o <= '0;
        end else begin
            div_go <= 1'b0;
            done_o <= 1'b0;
            case (state)
                S_IDLE: if (start_i) begin
                    tgt_q   <= target_i;
                    ref_q   <= refclk_i;
                    w_eref  <= 1'b0;
                    w_enos  <= 1'b0;
                    div_num <= NUM_W'(refclk_i);
                    div_den <= FREQ_W'(WIN_LO);
                    div_go  <= 1'b1;
                    busy_o  <= 1'b1;
                    state   <= S_MAXP;
                end
                S_MAXP: if (div_done) begin
                    max_pre <= div_quo[PRE_W-1:0];
                    div_num <= NUM_W'(ref_q);
                    div_den <= FREQ_W'(WIN_HI);
                    div_go  <= 1'b1;
                    state   <= S_MINP;
                end
                S_MINP: if (div_done) begin
                    min_pre <= (div_quo == '0) ? PRE_W'(1) : div_quo[PRE_W-1:0] + PRE_W'(1);
                    div_num <= NUM_W'(tgt_q);
                    div_den <= FREQ_W'(VCO_STEP);
                    div_go  <= 1'b1;
                    state   <= S_VCOR;
                end
                S_VCOR: if (div_done) begin
                    band_w <= div_quo[3:0];
                    state  <= S_CHK;
                end
                S_CHK: begin
                    if (max_pre < min_pre) begin
                        w_eref <= 1'b1;
                        state  <= S_DONE;
                    end else if (max_pre == min_pre) begin
                        w_enos <= 1'b1;
                        state  <= S_DONE;
                    end else begin
                        cand     <= min_pre;
                        best_rem <= '1;
                        found    <= 1'b0;
                        div_num  <= NUM_W'(tgt_q) * NUM_W'(min_pre);
                        div_den  <= ref_q;
                        div_go   <= 1'b1;
                        state    <= S_SRCH;
                    end
                end
                S_SRCH: if (div_done) begin
                    if (take) begin
                        best_rem <= div_rem;
                        best_pre <= cand;
                        best_fb  <= div_quo[FB_W-1:0];
                        found    <= 1'b1;
                    end
                    if (nxt_pre < max_pre) begin
                        cand    <= nxt_pre;
                        div_num <= NUM_W'(tgt_q) * NUM_W'(nxt_pre);
                        div_go  <= 1'b1;
                    end else if (found || take) begin
                        div_num <= NUM_W'(ref_q) * NUM_W'(sel_fb);
                        div_den <= FREQ_W'(sel_pre);
                        div_go  <= 1'b1;
                        state   <= S_RATE;
                    end else begin
                        w_enos <= 1'b1;
                        state  <= S_DONE;
                    end
                end
                S_RATE: if (div_done) begin
                    rate_w <= div_quo[FREQ_W-1:0];
                    state  <= S_DONE;
                end
                default: begin
                    res_ok      <= !(w_eref || w_enos);
                    err_ref_o   <= w_eref;
                    err_nosol_o <= w_enos;
                    prediv_o    <= (w_eref || w_enos) ? '0 : best_pre;
                    fbdiv_o     <= (w_eref || w_enos) ? '0 : best_fb;
                    rate_o      <= (w_eref || w_enos) ? '0 : rate_w;
                    band_o      <= band_w;
                    busy_o      <= 1'b0;
                    done_o      <= 1'b1;
                    state       <= S_IDLE;
                end
            endcase
        end
    end

    pll_code_pack #(.PRE_W(PRE_W), .FB_W(FB_W)) pack_u (
        .ok_i(res_ok), .prediv_i(prediv_o), .fbdiv_i(fbdiv_o),
        .vco_band_i(band_o), .in_div_byte_o(in_div_byte_o),
        .fb_lo_byte_o(fb_lo_byte_o), .fb_hi_byte_o(fb_hi_byte_o),
        .vco_byte_o(vco_byte_o)
    );

    // R8: done is a single-cycle pulse.
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R2, R5: the two error outcomes never appear together.
    a_r5_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_ref_o && err_nosol_o));

    // R1, R3: a successful choice lies inside the searched window.
    a_r3_pre_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && res_ok) |-> (prediv_o >= min_pre && prediv_o < max_pre));

    // R8: results stay put while idle.
    a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && !start_i) |=> ($stable(prediv_o) && $stable(fbdiv_o)
            && $stable(rate_o) && $stable(err_ref_o) && $stable(err_nosol_o)));

    // R8: the shared divider is never started while it is still working.
    a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        div_go |-> !div_busy);

endmodule

// File: tb/pll_div_search_tb.sv
// Scoreboard bench: the driver pushes model results, the monitor compares at done.
module pll_div_search_tb_top;
    localparam int FREQ_W = 24;

    typedef struct {
        logic   eref, enos;
        longint pre, fb, rate, bin, blo, bhi, bvco;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [FREQ_W-1:0] target_i = '0, refclk_i = '0;
    logic busy_o, done_o, err_ref_o, err_nosol_o;
    logic [11:0] prediv_o;
    logic [8:0]  fbdiv_o;
    logic [FREQ_W-1:0] rate_o;
    logic [7:0] in_div_byte_o, fb_lo_byte_o, fb_hi_byte_o, vco_byte_o;

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;
    bit prev_done = 0;
    exp_t exp_q[$];
    exp_t last_e;

    always #5 clk = ~clk;

    pll_div_search dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .target_i(target_i),
        .refclk_i(refclk_i), .busy_o(busy_o), .done_o(done_o),
        .err_ref_o(err_ref_o), .err_nosol_o(err_nosol_o), .prediv_o(prediv_o),
        .fbdiv_o(fbdiv_o), .rate_o(rate_o), .in_div_byte_o(in_div_byte_o),
        .fb_lo_byte_o(fb_lo_byte_o), .fb_hi_byte_o(fb_hi_byte_o),
        .vco_byte_o(vco_byte_o)
    );

    task automatic chk(string req, string what, longint act, longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected result computed from the requirements.
    function automatic exp_t model(longint t, longint r);
        exp_t e;
        longint maxp, minp, best, q, rm;
        bit found;
        e = '{eref: 0, enos: 0, pre: 0, fb: 0, rate: 0, bin: 0, blo: 0, bhi: 0, bvco: 0};
        maxp = r / 5000;
        minp = (r / 40000 == 0) ? 1 : r / 40000 + 1;
        if (maxp < minp) begin
            e.eref = 1;
            return e;
        end
        best = 64'h7FFF_FFFF_FFFF_FFFF;
        found = 0;
        for (longint i = minp; i < maxp; i++) begin
            q  = (t * i) / r;
            rm = (t * i) % r;
            if (rm < best && q < 512) begin
                best = rm; e.pre = i; e.fb = q; found = 1;
            end
        end
        if (!found) begin
            e.enos = 1; e.pre = 0; e.fb = 0;
            return e;
        end
        e.rate = r * e.fb / e.pre;
        e.bin  = (e.pre - 1) & 8'hFF;
        e.blo  = (e.fb - 1) & 8'h1F;
        e.bhi  = (((e.fb - 1) >> 5) | 8'h80) & 8'hFF;
        e.bvco = 8'h80 | (((t / 200000) & 4'hF) << 3) | 3;
        return e;
    endfunction

    task automatic compare(exp_t e, string tag);
        chk("R1 R2", {tag, " err_ref"}, err_ref_o, e.eref);
        chk("R5", {tag, " err_nosol"}, err_nosol_o, e.enos);
        chk("R3", {tag, " prediv"}, prediv_o, e.pre);
        chk("R4", {tag, " fbdiv"}, fbdiv_o, e.fb);
        chk("R4", {tag, " rate"}, rate_o, e.rate);
        chk("R6", {tag, " in_div byte"}, in_div_byte_o, e.bin);
        chk("R6", {tag, " fb_lo byte"}, fb_lo_byte_o, e.blo);
        chk("R6", {tag, " fb_hi byte"}, fb_hi_byte_o, e.bhi);
        chk("R7", {tag, " vco byte"}, vco_byte_o, e.bvco);
    endtask

    // Monitor: pops the expected item on each done pulse; checks the pulse width (R8).
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_done && done_o) chk("R8", "done width", 1, 0);
            prev_done = done_o;
            if (done_o) begin
                if (exp_q.size() == 0) chk("R8", "unexpected done", 1, 0);
                else compare(exp_q.pop_front(), "run");
            end
        end
    end

    // Driver: one start pulse, expected item pushed to the scoreboard.
    task automatic run(longint t, longint r);
        last_e = model(t, r);
        exp_q.push_back(last_e);
        @(negedge clk);
        target_i = FREQ_W'(t); refclk_i = FREQ_W'(r); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R8", "busy after start", busy_o, 1);
        wait (exp_q.size() == 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9", "busy", busy_o, 0);
        chk("R9", "done", done_o, 0);
        chk("R9", "errors", {err_ref_o, err_nosol_o}, 0);
        chk("R9", "prediv", prediv_o, 0);
        chk("R9", "bytes", {in_div_byte_o, fb_hi_byte_o, vco_byte_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        run(480000, 24000);    // R3 ties: all remainders 0, lowest kept
        run(891000, 24000);    // typical rate, 24 MHz reference
        run(1500000, 24000);
        run(891000, 100000);   // window starts at 3
        run(5005000, 30000);   // R3 best remainders need fb >= 512
        run(4000000, 4000);    // R2 bound inversion
        run(891000, 0);        // R2 zero reference
        run(7000000, 12000);   // R5 only candidate overflows fb limit

        // R8: start while busy is ignored
        last_e = model(2000000, 24000);
        exp_q.push_back(last_e);
        @(negedge clk);
        target_i = 24'd2000000; refclk_i = 24'd24000; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (10) @(negedge clk);
        target_i = 24'd891000; refclk_i = 24'd4000; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait (exp_q.size() == 0);

        // R8: outputs hold between runs
        repeat (20) @(negedge clk);
        chk("R8", "busy idle", busy_o, 0);
        compare(last_e, "hold");

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++; n_bad++;
            $display("FAIL R8 watchdog: actual 1 expected 0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule